// File: doc/BRIEF.md
# Tagged Object Pointer Identity Comparator

This block decides whether two tagged object pointers name the same object. A pointer carries an object size, a flag telling whether it holds the object's canonical (home) address, and a 48-bit hardware address. The address space is split into non-overlapping windows, one per storage level, and the first-level window is set by parameters. When both operands are canonical, or both are first-level copies, the addresses are compared directly. When one is canonical and the other is a copy, the copy's header is read through a variable-latency read port. The header returns the canonical address of the copy, and that address is compared with the canonical operand.

A requester hands over both pointers with a valid/ready handshake. One cycle later, or one cycle after the header read completes, the block presents an equal/error result. It holds that result until the requester takes it. Only after that does it accept the next pair.

Top module: `ptr_id_cmp`

## Requirements
- R1: A pointer is 64 bits wide: bits 47..0 are the hardware address, bit 48 is set for a canonical pointer and clear for a copy, and bits 62..49 are the object size.
- R2: The size field and bit 63 have no effect on the result.
- R3: Two canonical pointers compare equal exactly when their addresses are equal, at any level, and no header read is issued.
- R4: Two non-canonical pointers inside the first-level window compare equal exactly when their addresses are equal, and no header read is issued.
- R5: With one canonical and one non-canonical operand, the block raises rd_req with rd_addr set to the non-canonical address. It holds both until rd_ack. The result is equal exactly when rd_data equals the canonical operand's address.
- R6: A non-canonical operand whose address lies outside [L1_BASE, L1_BASE+L1_SPAN-1] gives res_error=1 and res_equal=0, and no header read is issued.
- R7: req_ready is 1 after reset and goes to 0 from acceptance until the cycle after the result is taken. res_valid, res_equal and res_error stay unchanged while res_ready is 0.
- R8: A direct or error result is valid in the cycle after acceptance. A mixed result is valid in the cycle after rd_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Pointer pair offered |
| req_ready | output | 1 | Block can take a pair |
| req_ptr_a | input | 64 | First tagged pointer |
| req_ptr_b | input | 64 | Second tagged pointer |
| rd_req | output | 1 | Header read pending |
| rd_addr | output | 48 | Address of the copy whose header is read |
| rd_ack | input | 1 | Header read complete, rd_data valid |
| rd_data | input | 48 | Canonical address from the header |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Requester takes the result |
| res_equal | output | 1 | Pointers name the same object |
| res_error | output | 1 | Copy pointer outside the first-level window |

## Verification
The bench builds the block with a 64 KiB first-level window placed at 0x4000_0000. With so small a window, operands one below the base, at the base, at the last address and one past the end can all be written out by hand. This exercises both sides of each window edge. Canonical operands placed far outside the window show that they are accepted at any level. Header replies with zero and multi-cycle delays are combined with a repeating result back-pressure pattern. Together these reach the hold-while-stalled and latency rules in both the direct and the mixed path.

// File: rtl/ptr_cmp_pkg.sv
package ptr_cmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } cmp_state_e;
endpackage

// File: rtl/ptr_decode.sv
module ptr_decode #(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 14,
  parameter logic [ADDR_W-1:0] L1_BASE = ADDR_W'(64'h0001_0000_0000),
  parameter logic [ADDR_W-1:0] L1_SPAN = ADDR_W'(64'h0000_1000_0000)
) (
  input  logic [SIZE_W+ADDR_W+1:0] ptr,
  output logic [ADDR_W-1:0]        addr,
  output logic                     canon,
  output logic                     in_l1
);
  localparam int PTR_W     = SIZE_W + ADDR_W + 2;
  localparam int CANON_BIT = ADDR_W;

  // offset-from-base test avoids overflow at the top of the space
  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - L1_BASE;
    return (a >= L1_BASE) && (off < L1_SPAN);
  endfunction

  // size and reserved bits take no part in identity
  logic meta_unused;
  assign meta_unused = ^ptr[PTR_W-1:CANON_BIT+1];

  assign addr  = ptr[ADDR_W-1:0];
  assign canon = ptr[CANON_BIT];
  assign in_l1 = in_window(ptr[ADDR_W-1:0]);
endmodule

// File: rtl/ptr_cmp_fsm.sv
module ptr_cmp_fsm
  import ptr_cmp_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              op_mixed,
  input  logic              op_bad,
  input  logic              op_direct_eq,
  input  logic [ADDR_W-1:0] op_canon_addr,
  input  logic [ADDR_W-1:0] op_copy_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_equal,
  output logic              res_error,
  output logic              take_req,
  output logic              fetch_done,
  output logic              res_take
);
  cmp_state_e        state_q;
  logic [ADDR_W-1:0] canon_q;
  logic [ADDR_W-1:0] copy_q;
  logic              eq_q;
  logic              err_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign rd_req     = (state_q == ST_FETCH);
  assign res_valid  = (state_q == ST_DONE);
  assign take_req   = req_valid && req_ready;
  assign fetch_done = rd_req && rd_ack;
  assign res_take   = res_valid && res_ready;
  assign rd_addr    = copy_q;
  assign res_equal  = eq_q;
  assign res_error  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      canon_q <= '0;
      copy_q  <= '0;
      eq_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take_req) begin
          if (op_bad) begin
            err_q   <= 1'b1;
            eq_q    <= 1'b0;
            state_q <= ST_DONE;
          end else if (op_mixed) begin
            err_q   <= 1'b0;
            canon_q <= op_canon_addr;
            copy_q  <= op_copy_addr;
            state_q <= ST_FETCH;
          end else begin
            err_q   <= 1'b0;
            eq_q    <= op_direct_eq;
            state_q <= ST_DONE;
          end
        end
        ST_FETCH: if (fetch_done) begin
          eq_q    <= (rd_data == canon_q);
          state_q <= ST_DONE;
        end
        ST_DONE: if (res_take) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptr_id_cmp.sv
module ptr_id_cmp #(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 14,
  parameter logic [ADDR_W-1:0] L1_BASE = ADDR_W'(64'h0001_0000_0000),
  parameter logic [ADDR_W-1:0] L1_SPAN = ADDR_W'(64'h0000_1000_0000),
  localparam int PTR_W = SIZE_W + ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PTR_W-1:0]  req_ptr_a,
  input  logic [PTR_W-1:0]  req_ptr_b,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_equal,
  output logic              res_error
);
  localparam int N_OPS = 2;

  logic [PTR_W-1:0]  ops     [N_OPS];
  logic [ADDR_W-1:0] op_addr [N_OPS];
  logic              op_can  [N_OPS];
  logic              op_l1   [N_OPS];

  assign ops[0] = req_ptr_a;
  assign ops[1] = req_ptr_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_dec
    ptr_decode #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W),
      .L1_BASE(L1_BASE),
      .L1_SPAN(L1_SPAN)
    ) u_dec (
      .ptr  (ops[g]),
      .addr (op_addr[g]),
      .canon(op_can[g]),
      .in_l1(op_l1[g])
    );
  end

  // operand classification, brought out for the checker
  logic              op_mixed;
  logic              op_bad;
  logic              op_direct_eq;
  logic [ADDR_W-1:0] op_canon_addr;
  logic [ADDR_W-1:0] op_copy_addr;

  always_comb begin
    op_mixed      = op_can[0] ^ op_can[1];
    op_bad        = (!op_can[0] && !op_l1[0]) || (!op_can[1] && !op_l1[1]);
    op_direct_eq  = (op_addr[0] == op_addr[1]);
    op_canon_addr = op_can[0] ? op_addr[0] : op_addr[1];
    op_copy_addr  = op_can[0] ? op_addr[1] : op_addr[0];
  end

  logic take_req;
  logic fetch_done;
  logic res_take;

  ptr_cmp_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .op_mixed     (op_mixed),
    .op_bad       (op_bad),
    .op_direct_eq (op_direct_eq),
    .op_canon_addr(op_canon_addr),
    .op_copy_addr (op_copy_addr),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_ack       (rd_ack),
    .rd_data      (rd_data),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_equal    (res_equal),
    .res_error    (res_error),
    .take_req     (take_req),
    .fetch_done   (fetch_done),
    .res_take     (res_take)
  );
endmodule

// File: rtl/ptr_cmp_chk.sv
module ptr_cmp_chk #(
  parameter int ADDR_W = 48,
  parameter logic [ADDR_W-1:0] L1_BASE = '0,
  parameter logic [ADDR_W-1:0] L1_SPAN = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_equal,
  input logic              res_error,
  input logic              take_req,
  input logic              fetch_done
);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_equal) && $stable(res_error));

  // R7
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> !req_ready);

  // R5
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R6
  read_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr >= L1_BASE) && ((rd_addr - L1_BASE) < L1_SPAN));

  // R6
  error_not_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_error |-> !res_equal);

  // R8
  fetch_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> res_valid);
endmodule

bind ptr_id_cmp ptr_cmp_chk #(
  .ADDR_W (ADDR_W),
  .L1_BASE(L1_BASE),
  .L1_SPAN(L1_SPAN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_ack    (rd_ack),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_equal (res_equal),
  .res_error (res_error),
  .take_req  (take_req),
  .fetch_done(fetch_done)
);

// File: tb/sim_ptr_id_cmp.sv
module sim_ptr_id_cmp;
  localparam logic [47:0] L1B = 48'h0000_4000_0000;
  localparam logic [47:0] L1S = 48'h0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ptr_a = '0;
  logic [63:0] req_ptr_b = '0;
  logic        rd_req;
  logic [47:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [47:0] rd_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_equal;
  logic        res_error;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  ptr_id_cmp #(.L1_BASE(L1B), .L1_SPAN(L1S)) u0 (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mkp(input bit resv, input logic [13:0] sz, input bit can, input logic [47:0] a);
    return {resv, sz, can, a};
  endfunction

  function automatic bit inside_l1(input logic [47:0] a);
    return (a >= L1B) && (a <= L1B + L1S - 48'd1);
  endfunction

  task automatic run_cmp(input logic [63:0] a, input logic [63:0] b,
                         input logic [47:0] hdr, input int dly, input string rq);
    bit ca, cb, bad, mixed, eq;
    logic [47:0] aa, ab, copy;
    ca = a[48]; cb = b[48]; aa = a[47:0]; ab = b[47:0];
    bad   = (!ca && !inside_l1(aa)) || (!cb && !inside_l1(ab));
    mixed = (ca != cb);
    copy  = ca ? ab : aa;
    if (bad) eq = 1'b0;
    else if (mixed) eq = (hdr == (ca ? aa : ab));
    else eq = (aa == ab);
    exp_q.push_back({bad, eq});
    tag_q.push_back(rq);
    req_ptr_a = a; req_ptr_b = b; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad || !mixed) begin
      // R8 direct/error latency, R3/R4/R6 no header read
      chk(res_valid && !rd_req, {rq, " R8 direct"}, {res_valid, rd_req}, 2'b10);
    end else begin
      // R5 header read address
      chk(rd_req && rd_addr == copy, {rq, " R5 read"}, {rd_req, rd_addr}, {1'b1, copy});
      repeat (dly) @(negedge clk);
      rd_ack = 1'b1; rd_data = hdr;
      @(negedge clk);
      rd_ack = 1'b0;
      // R8 mixed latency
      chk(res_valid && !rd_req, {rq, " R8 mixed"}, {res_valid, rd_req}, 2'b10);
    end
  endtask

  // monitor / scoreboard
  int  k = 0;
  bit  hold_pend = 1'b0;
  logic [1:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(res_valid && {res_error, res_equal} == held, "R7 hold",
            {res_valid, res_error, res_equal}, {1'b1, held});
      hold_pend = 1'b0;
      k++;
      res_ready = (k % 4 != 1);
      if (res_valid) begin
        chk(!req_ready, "R7 busy", req_ready, 0);
        if (res_ready) begin
          if (exp_q.size() == 0) chk(1'b0, "R7 spurious", 1, 0);
          else begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({res_error, res_equal} == e, t, {res_error, res_equal}, e);
          end
        end else begin
          hold_pend = 1'b1;
          held = {res_error, res_equal};
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(req_ready && !res_valid && !rd_req, "R7 reset", {req_ready, res_valid, rd_req}, 3'b100);

    // R1 R2 R3: size and bit 63 differ, canonical addresses match
    run_cmp(mkp(1, 14'h0005, 1, 48'h7000_0000_1234), mkp(0, 14'h3FFF, 1, 48'h7000_0000_1234), '0, 0, "R2");
    // R3: canonical, different address
    run_cmp(mkp(0, 14'h10, 1, 48'h7000_0000_1234), mkp(0, 14'h10, 1, 48'h7000_0000_1238), '0, 0, "R3");
    // R4: copies in window
    run_cmp(mkp(0, 14'h2, 0, L1B + 48'h40), mkp(1, 14'h9, 0, L1B + 48'h40), '0, 0, "R4");
    run_cmp(mkp(0, 14'h2, 0, L1B + 48'h40), mkp(0, 14'h2, 0, L1B + 48'h48), '0, 0, "R4");
    // R6: window boundaries
    run_cmp(mkp(0, 14'h2, 0, L1B - 48'd1), mkp(0, 14'h2, 0, L1B), '0, 0, "R6");
    run_cmp(mkp(0, 14'h2, 0, L1B), mkp(0, 14'h2, 0, L1B + L1S), '0, 0, "R6");
    run_cmp(mkp(1, 14'h2, 1, 48'h1), mkp(0, 14'h2, 0, L1B + L1S), 48'h1, 0, "R6");
    run_cmp(mkp(0, 14'h2, 0, L1B + L1S - 48'd1), mkp(0, 14'h2, 0, L1B), '0, 0, "R4");
    // R5: mixed, matching header, no delay
    run_cmp(mkp(0, 14'h4, 1, 48'h9000_0000_0100), mkp(0, 14'h4, 0, L1B + 48'h80), 48'h9000_0000_0100, 0, "R5");
    // R5: mismatching header, long delay
    run_cmp(mkp(0, 14'h4, 1, 48'h9000_0000_0100), mkp(0, 14'h4, 0, L1B + 48'h80), 48'h9000_0000_0108, 4, "R5");
    // R5: copy first, canonical second
    run_cmp(mkp(1, 14'h7, 0, L1B + L1S - 48'd1), mkp(0, 14'h1, 1, 48'h0000_0000_0020), 48'h20, 2, "R5");
    // R1: same address number, only flag differs -> mixed path
    run_cmp(mkp(0, 14'h3, 1, L1B + 48'h10), mkp(0, 14'h3, 0, L1B + 48'h10), 48'h5555, 1, "R1");
    // R3: canonical addresses inside window also compare directly
    run_cmp(mkp(0, 14'h3, 1, L1B), mkp(0, 14'h3, 1, L1B), '0, 0, "R3");

    while (exp_q.size() != 0 || res_valid) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule